// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block holds the control state of a set of physical memory protection entries: one configuration byte and one 32-bit address word per entry, plus a three-bit security control register. A core writes and reads this state through a simple CSR port made of a space select, an index, a write strobe, write data and combinational read data. Configuration bytes are packed four to a 32-bit word, so index r in the configuration space reaches entries 4r to 4r+3. The raw register contents go out on flat buses to a separate range decoder and permission checker.

Every write passes a lock policy before it takes effect. In standard mode an entry's own lock bit freezes its configuration byte. In enhanced mode a bypass bit and a lockdown bit change that rule. An address word is frozen by its own lock, and also when the next entry is locked and uses top-of-range matching, because that next entry takes its lower bound from this word. In the security register the bypass bit cannot be raised while any entry is locked, and the lockdown and whitelist bits are sticky until reset.

Top module: `pmp_csr_bank`

## Requirements
- R1: All configuration, address and security state resets to zero on synchronous active-high `rst`, and an accepted write becomes visible on the outputs at the clock edge that samples `csr_we` high, not before.
- R2: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. A configuration write at index r sends byte i of `csr_wdata` (bits 8i+7:8i) to entry 4r+i, and a read at index r returns those four bytes in the same positions.
- R3: With `enh_en` low, a configuration byte write to an entry whose lock bit is set is dropped, whatever the security register holds.
- R4: With `enh_en` high, a configuration byte write is accepted when the bypass bit is set, or when lockdown is clear and the entry is unlocked, or when lockdown is set and the new byte has lock set and execute clear, or when lockdown is set and the new byte has lock clear and bits 2:0 are not exactly 3'b110. Otherwise it is dropped.
- R5: An address write to entry i is dropped when entry i+1 exists, is locked, and has match mode 1 (top-of-range). A locked entry i+1 with any other mode does not block it.
- R6: An address write to entry i is dropped when entry i's own lock bit is set.
- R7: A security write stores the lockdown and whitelist bits and stores the bypass bit only if the bypass bit is already set or no entry is locked; otherwise the bypass bit is stored as 0 while the rest of the write still completes.
- R8: Lockdown and whitelist bits, once set, stay set until reset; writing 0 to them has no effect.
- R9: Writes to a configuration index at or beyond N_ENTRIES/4 or to an address index at or beyond N_ENTRIES change nothing, and reads of such indices return zero.
- R10: `csr_space` selects 0 configuration, 1 address, 2 security, 3 unused (writes ignored, reads zero). Security read data holds lockdown in bit 0, whitelist in bit 1, bypass in bit 2, zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_en | input | 1 | Enhanced lock policy enable |
| csr_we | input | 1 | Write strobe for one cycle per write |
| csr_space | input | 2 | Register space select |
| csr_idx | input | IDX_W | Word index within the selected space |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for space and index |
| cfg_o | output | N_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| addr_o | output | N_ENTRIES*32 | All address words, entry e at bits 32e+31:32e |
| sec_mml | output | 1 | Lockdown bit |
| sec_mmwp | output | 1 | Whitelist bit |
| sec_rlb | output | 1 | Lock bypass bit |

## Verification
The properties take for granted that the space select, index, data and `enh_en` are known and steady around each rising edge, and that `csr_we` is a single-cycle strobe whose accompanying fields match the write it carries. The bench meets this by changing every input only on the falling edge and holding it for a whole cycle, and by driving all inputs to known values before reset ends. The checks on lock freezing rely on `enh_en` being constant across the cycle of the write, which the bench keeps by setting it together with the other write fields.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    localparam int XLEN          = 32;
    localparam int BYTES_PER_CSR = XLEN / 8;

    typedef enum logic [1:0] {
        SP_CFG  = 2'd0,
        SP_ADDR = 2'd1,
        SP_SEC  = 2'd2,
        SP_NONE = 2'd3
    } csr_space_e;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     amode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef struct packed {
        logic rlb;
        logic mmwp;
        logic mml;
    } sec_t;

    function automatic logic cfg_write_ok(logic enh, sec_t sec, cfg_t cur, cfg_t nw);
        logic shared_wx;
        shared_wx = ({nw.x, nw.w, nw.r} == 3'b110);
        if (!enh)
            return !cur.lock;
        return sec.rlb
            | (!sec.mml & !cur.lock)
            | (sec.mml & nw.lock & !nw.x)
            | (sec.mml & !nw.lock & !shared_wx);
    endfunction

    function automatic logic addr_write_ok(cfg_t own, logic has_next, cfg_t nxt);
        logic tor_guard;
        tor_guard = has_next & nxt.lock & (nxt.amode == AM_TOR);
        return !tor_guard & !own.lock;
    endfunction

endpackage

// File: rtl/pmp_entry_reg.sv
module pmp_entry_reg
    import pmp_csr_pkg::*;
#(
    parameter bit HAS_NEXT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enh_en,
    input  sec_t            sec,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wbyte,
    input  logic            addr_we,
    input  logic [XLEN-1:0] addr_wdata,
    input  cfg_t            next_cfg,
    output cfg_t            cfg_q,
    output logic [XLEN-1:0] addr_q
);

    logic cfg_take;
    logic addr_take;

    always_comb begin
        cfg_take  = cfg_we  && cfg_write_ok(enh_en, sec, cfg_q, cfg_t'(cfg_wbyte));
        addr_take = addr_we && addr_write_ok(cfg_q, HAS_NEXT, next_cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cfg_take)
                cfg_q <= cfg_t'(cfg_wbyte);
            if (addr_take)
                addr_q <= addr_wdata;
        end
    end

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
    import pmp_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [2:0] wbits,
    input  logic       any_locked,
    output sec_t       sec_q
);

    sec_t wr;

    always_comb begin
        wr      = sec_t'(wbits);
        wr.mml  = wr.mml  | sec_q.mml;
        wr.mmwp = wr.mmwp | sec_q.mmwp;
        wr.rlb  = wr.rlb  & (sec_q.rlb | !any_locked);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sec_q <= '0;
        else if (we)
            sec_q <= wr;
    end

endmodule

// File: rtl/pmp_csr_rmux.sv
module pmp_csr_rmux
    import pmp_csr_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 8
) (
    input  logic [1:0]       space,
    input  logic [IDX_W-1:0] idx,
    input  cfg_t             cfg_all  [N_ENTRIES],
    input  logic [XLEN-1:0]  addr_all [N_ENTRIES],
    input  sec_t             sec,
    output logic [XLEN-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        case (csr_space_e'(space))
            SP_CFG: begin
                for (int e = 0; e < N_ENTRIES; e++) begin
                    if (idx == IDX_W'(e / BYTES_PER_CSR))
                        rdata[(e % BYTES_PER_CSR)*8 +: 8] = cfg_all[e];
                end
            end
            SP_ADDR: begin
                for (int e = 0; e < N_ENTRIES; e++) begin
                    if (idx == IDX_W'(e))
                        rdata = addr_all[e];
                end
            end
            SP_SEC:  rdata[2:0] = sec;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_csr_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enh_en,
    input  logic                      csr_we,
    input  logic [1:0]                csr_space,
    input  logic [IDX_W-1:0]          csr_idx,
    input  logic [XLEN-1:0]           csr_wdata,
    output logic [XLEN-1:0]           csr_rdata,
    output logic [N_ENTRIES*8-1:0]    cfg_o,
    output logic [N_ENTRIES*XLEN-1:0] addr_o,
    output logic                      sec_mml,
    output logic                      sec_mmwp,
    output logic                      sec_rlb
);

    cfg_t            cfg_q  [N_ENTRIES];
    logic [XLEN-1:0] addr_q [N_ENTRIES];
    sec_t            sec_q;
    logic            any_locked;
    logic            cfg_space_we;
    logic            addr_space_we;
    logic            sec_space_we;

    assign cfg_space_we  = csr_we && (csr_space_e'(csr_space) == SP_CFG);
    assign addr_space_we = csr_we && (csr_space_e'(csr_space) == SP_ADDR);
    assign sec_space_we  = csr_we && (csr_space_e'(csr_space) == SP_SEC);

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        localparam bit LAST = (e == N_ENTRIES - 1);
        cfg_t nxt;
        logic ent_cfg_we;
        logic ent_addr_we;

        if (LAST) begin : g_last
            assign nxt = '0;
        end else begin : g_mid
            assign nxt = cfg_q[e+1];
        end

        assign ent_cfg_we  = cfg_space_we  && (csr_idx == IDX_W'(e / BYTES_PER_CSR));
        assign ent_addr_we = addr_space_we && (csr_idx == IDX_W'(e));

        pmp_entry_reg #(.HAS_NEXT(!LAST)) u_ent (
            .clk        (clk),
            .rst        (rst),
            .enh_en     (enh_en),
            .sec        (sec_q),
            .cfg_we     (ent_cfg_we),
            .cfg_wbyte  (csr_wdata[(e % BYTES_PER_CSR)*8 +: 8]),
            .addr_we    (ent_addr_we),
            .addr_wdata (csr_wdata),
            .next_cfg   (nxt),
            .cfg_q      (cfg_q[e]),
            .addr_q     (addr_q[e])
        );

        assign cfg_o[e*8 +: 8]     = cfg_q[e];
        assign addr_o[e*XLEN +: XLEN] = addr_q[e];
    end

    always_comb begin
        any_locked = 1'b0;
        for (int e = 0; e < N_ENTRIES; e++)
            any_locked = any_locked | cfg_q[e].lock;
    end

    pmp_sec_reg u_sec (
        .clk        (clk),
        .rst        (rst),
        .we         (sec_space_we),
        .wbits      (csr_wdata[2:0]),
        .any_locked (any_locked),
        .sec_q      (sec_q)
    );

    pmp_csr_rmux #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_rmux (
        .space    (csr_space),
        .idx      (csr_idx),
        .cfg_all  (cfg_q),
        .addr_all (addr_q),
        .sec      (sec_q),
        .rdata    (csr_rdata)
    );

    assign sec_mml  = sec_q.mml;
    assign sec_mmwp = sec_q.mmwp;
    assign sec_rlb  = sec_q.rlb;

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
    parameter int N_ENTRIES = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    enh_en,
    input logic                    csr_we,
    input logic [N_ENTRIES*8-1:0]  cfg_o,
    input logic [N_ENTRIES*32-1:0] addr_o,
    input logic                    sec_mml,
    input logic                    sec_mmwp,
    input logic                    sec_rlb
);

    logic any_lk;

    always_comb begin
        any_lk = 1'b0;
        for (int e = 0; e < N_ENTRIES; e++)
            any_lk = any_lk | cfg_o[e*8+7];
    end

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_o == '0 && addr_o == '0 && !sec_mml && !sec_mmwp && !sec_rlb));

    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> ($stable(cfg_o) && $stable(addr_o) && $stable(sec_mml)
                     && $stable(sec_mmwp) && $stable(sec_rlb)));

    a_r8_mml_sticky: assert property (@(posedge clk) disable iff (rst)
        sec_mml |=> sec_mml);

    a_r8_mmwp_sticky: assert property (@(posedge clk) disable iff (rst)
        sec_mmwp |=> sec_mmwp);

    a_r7_rlb_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_rlb) |-> $past(!any_lk));

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_chk
        a_r3_std_lock_cfg: assert property (@(posedge clk) disable iff (rst)
            (!enh_en && cfg_o[e*8+7]) |=> $stable(cfg_o[e*8 +: 8]));

        a_r6_own_lock_addr: assert property (@(posedge clk) disable iff (rst)
            cfg_o[e*8+7] |=> $stable(addr_o[e*32 +: 32]));
    end

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enh_en   (enh_en),
    .csr_we   (csr_we),
    .cfg_o    (cfg_o),
    .addr_o   (addr_o),
    .sec_mml  (sec_mml),
    .sec_mmwp (sec_mmwp),
    .sec_rlb  (sec_rlb)
);

// File: tb/tb_pmp_csr_bank.sv
module tb_pmp_csr_bank;

    localparam int N  = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enh_en = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_space = 2'd0;
    logic [IW-1:0] csr_idx = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic [N*8-1:0]  cfg_o;
    logic [N*32-1:0] addr_o;
    logic sec_mml, sec_mmwp, sec_rlb;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pmp_csr_bank #(.N_ENTRIES(N), .IDX_W(IW)) dut (
        .clk(clk), .rst(rst), .enh_en(enh_en), .csr_we(csr_we),
        .csr_space(csr_space), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .cfg_o(cfg_o), .addr_o(addr_o),
        .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb)
    );

    typedef struct packed {
        logic [1:0]  wsp;
        logic [7:0]  widx;
        logic [31:0] wdat;
        logic        enh;
        logic [1:0]  rsp;
        logic [7:0]  ridx;
        logic [31:0] expv;
        logic [31:0] tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd0,  32'h1B0F0301, 1'b0, 2'd0, 8'd0,  32'h1B0F0301, "R2"},
        '{2'd1, 8'd5,  32'h12345678, 1'b0, 2'd1, 8'd5,  32'h12345678, "R10"},
        '{2'd0, 8'd1,  32'h00880000, 1'b0, 2'd0, 8'd1,  32'h00880000, "R2"},
        '{2'd1, 8'd5,  32'hDEADBEEF, 1'b0, 2'd1, 8'd5,  32'h12345678, "R5"},
        '{2'd0, 8'd1,  32'h00000000, 1'b0, 2'd0, 8'd1,  32'h00880000, "R3"},
        '{2'd1, 8'd6,  32'hAAAA5555, 1'b0, 2'd1, 8'd6,  32'h00000000, "R6"},
        '{2'd1, 8'd4,  32'h00000444, 1'b0, 2'd1, 8'd4,  32'h00000444, "R5"},
        '{2'd0, 8'd2,  32'h00009800, 1'b0, 2'd0, 8'd2,  32'h00009800, "R2"},
        '{2'd1, 8'd8,  32'h00000888, 1'b0, 2'd1, 8'd8,  32'h00000888, "R5"},
        '{2'd2, 8'd0,  32'h00000004, 1'b0, 2'd2, 8'd0,  32'h00000000, "R7"},
        '{2'd2, 8'd0,  32'h00000002, 1'b0, 2'd2, 8'd0,  32'h00000002, "R7"},
        '{2'd2, 8'd0,  32'h00000000, 1'b0, 2'd2, 8'd0,  32'h00000002, "R8"},
        '{2'd0, 8'd4,  32'hFFFFFFFF, 1'b0, 2'd0, 8'd4,  32'h00000000, "R9"},
        '{2'd3, 8'd0,  32'hFFFFFFFF, 1'b0, 2'd0, 8'd0,  32'h1B0F0301, "R10"},
        '{2'd1, 8'd16, 32'hFFFFFFFF, 1'b0, 2'd1, 8'd16, 32'h00000000, "R9"},
        '{2'd0, 8'd1,  32'h00000000, 1'b1, 2'd0, 8'd1,  32'h00880000, "R4"},
        '{2'd1, 8'd7,  32'h00000777, 1'b1, 2'd1, 8'd7,  32'h00000777, "R5"}
    };

    task automatic chk(input string what, input string req, input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, expv);
        end
    endtask

    task automatic wr(input logic [1:0] sp, input logic [7:0] idx, input logic [31:0] dat, input logic enh);
        @(negedge clk);
        csr_space = sp;
        csr_idx   = idx;
        csr_wdata = dat;
        enh_en    = enh;
        csr_we    = 1'b1;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sp, input logic [7:0] idx, output logic [31:0] dat);
        csr_space = sp;
        csr_idx   = idx;
        #1;
        dat = csr_rdata;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("reset cfg", "R1", {31'd0, |cfg_o}, 32'd0);
        chk("reset addr", "R1", {31'd0, |addr_o}, 32'd0);
        rd(2'd2, 8'd0, r);
        chk("reset sec", "R1", r, 32'd0);

        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].wsp, VECS[v].widx, VECS[v].wdat, VECS[v].enh);
            rd(VECS[v].rsp, VECS[v].ridx, r);
            chk($sformatf("vector %0d", v), $sformatf("%s", VECS[v].tag), r, VECS[v].expv);
        end

        // second phase from a fresh reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("re-reset cfg", "R1", {31'd0, |cfg_o}, 32'd0);

        // R1 timing: bypass bit appears only after the sampling edge
        @(negedge clk);
        csr_space = 2'd2; csr_idx = '0; csr_wdata = 32'h4; enh_en = 1'b1; csr_we = 1'b1;
        #1;
        chk("rlb before edge", "R1", {31'd0, sec_rlb}, 32'd0);
        @(negedge clk);
        csr_we = 1'b0;
        chk("rlb after edge", "R7", {31'd0, sec_rlb}, 32'd1);

        wr(2'd0, 8'd0, 32'h00000081, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("lock entry0", "R4", r, 32'h00000081);
        wr(2'd0, 8'd0, 32'h00000003, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("bypass rewrites locked", "R4", r, 32'h00000003);
        wr(2'd0, 8'd0, 32'h00000083, 1'b1);
        wr(2'd0, 8'd0, 32'h00000000, 1'b0);
        rd(2'd0, 8'd0, r);
        chk("standard ignores bypass", "R3", r, 32'h00000083);

        wr(2'd2, 8'd0, 32'h00000004, 1'b1);
        rd(2'd2, 8'd0, r);
        chk("bypass kept while locked", "R7", r, 32'h00000004);
        wr(2'd2, 8'd0, 32'h00000005, 1'b1);
        wr(2'd2, 8'd0, 32'h00000001, 1'b1);
        rd(2'd2, 8'd0, r);
        chk("lockdown sticky, bypass cleared", "R8", r, 32'h00000001);
        chk("lockdown port", "R8", {31'd0, sec_mml}, 32'd1);

        wr(2'd0, 8'd0, 32'h00000081, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("lockdown L set X clear", "R4", r, 32'h00000081);
        wr(2'd0, 8'd0, 32'h00000084, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("lockdown L set X set", "R4", r, 32'h00000081);
        wr(2'd0, 8'd0, 32'h00000006, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("lockdown shared WX", "R4", r, 32'h00000081);
        wr(2'd0, 8'd0, 32'h00000007, 1'b1);
        rd(2'd0, 8'd0, r);
        chk("lockdown L clear RWX", "R4", r, 32'h00000007);

        wr(2'd2, 8'd0, 32'h00000004, 1'b1);
        rd(2'd2, 8'd0, r);
        chk("bypass allowed when none locked", "R7", r, 32'h00000005);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule